// File: doc/BRIEF.md
# Reset Cause Controller

This block merges every reset source of a small microcontroller into one internal reset and remembers which source produced the most recent one. The sources are a synchronous power-on request, a supply-low monitor, an external active-low reset pin, a watchdog expiry, a lost-clock detector, an active-low comparator output, an active-low convert-start line and two software requests. The asynchronous event lines pass through two-flop synchronizers. The internal reset is then held for a fixed number of cycles after the last active source goes away.

Software sees one 8-bit location. A write arms or disarms the optional sources and can request a warm reset or a power-on-style reset. The power-on-style reset also asks the board to pull the reset pin low. A read returns a one-hot cause code for the last reset. Writes are dropped while the internal reset is asserted.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The read value has bit 7 always 0 and exactly one cause bit set. The bit positions are: 6 convert-start, 5 comparator, 4 software warm reset, 3 watchdog, 2 lost clock, 1 power-on/supply class, 0 reset pin.
- R2: While `por_i` is high, `sys_rst_o` is high. After it is released, the read value is 0x02 and all source enables are 0.
- R3: Write bits 6, 5 and 2 arm (1) or disarm (0) the convert-start, comparator and lost-clock sources. A low on the convert-start or comparator line, or a high on the lost-clock line, causes a reset only while its arm bit is set.
- R4: A supply-low event causes a reset, cause 0x02, only when `mon_en_i` is high and write bit 1 is set.
- R5: Writing 1 to bit 4 starts an internal reset with cause 0x10 and never asserts `pin_drive_o`. A write with bits 4 and 0 both 0 starts no reset.
- R6: Writing 1 to bit 0 starts a power-on-style reset with cause 0x02 and asserts `pin_drive_o` for exactly STRETCH cycles.
- R7: The reset pin (low) and the watchdog line (high) always cause a reset, with causes 0x01 and 0x08.
- R8: When several sources start a reset in the same cycle, the cause is chosen in this order: power-on class, pin, lost clock, watchdog, software, comparator, convert-start.
- R9: The cause is captured only when a reset starts from the idle state and is held unchanged otherwise.
- R10: `sys_rst_o` rises the cycle after an active synchronized source and stays high for STRETCH cycles after the last active one. A one-cycle software request gives STRETCH+1 high cycles. A pin release gives STRETCH+2 high cycles, counted from the first edge after release, because of the two-flop synchronizer.
- R11: Source enables survive warm resets and are cleared by any power-on-class reset.
- R12: Writes made while `sys_rst_o` is high change no enable and start no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Synchronous active-high power-on reset |
| mon_en_i | input | 1 | Board strap that enables the supply monitor circuit |
| supply_low_i | input | 1 | Asynchronous supply-low event |
| pin_rst_n_i | input | 1 | Asynchronous external reset pin, active low |
| wdt_expire_i | input | 1 | Asynchronous watchdog expiry |
| clk_lost_i | input | 1 | Asynchronous lost-clock event |
| cmp_out_i | input | 1 | Asynchronous comparator output, reset when low |
| cnv_start_n_i | input | 1 | Asynchronous convert-start line, reset when low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Cause code of the last reset |
| sys_rst_o | output | 1 | Stretched internal reset |
| pin_drive_o | output | 1 | Request to pull the reset pin low |

## Verification
A wrong cause register shows on `rdata_o` as soon as the stretch window ends. It shows as a missing bit, two set bits, or a priority loser winning. A wrong enable is invisible until the matching source toggles: the reset then either fails to appear within the synchronizer delay or appears when it should not. For that reason each enable is checked by a later source event, not by a read. A wrong stretch counter changes the number of high cycles on `sys_rst_o` and `pin_drive_o`, so the bench counts those cycles exactly.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NSRC   = 7;
  localparam int B_PIN  = 0;
  localparam int B_POR  = 1;
  localparam int B_MCD  = 2;
  localparam int B_WDT  = 3;
  localparam int B_SW   = 4;
  localparam int B_CMP  = 5;
  localparam int B_CNV  = 6;

  typedef logic [NSRC-1:0] src_t;

  typedef struct packed {
    logic cnv;
    logic cmp;
    logic mcd;
    logic mon;
  } en_t;

  // highest priority first
  localparam int PRIO [NSRC] = '{B_POR, B_PIN, B_MCD, B_WDT, B_SW, B_CMP, B_CNV};

  function automatic src_t pick_cause(input src_t s);
    src_t r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (s[PRIO[i]]) r = src_t'(1) << PRIO[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int           W    = 6,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic meta_q, sync_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          meta_q <= IDLE[g];
          sync_q <= IDLE[g];
        end else begin
          meta_q <= d_i[g];
          sync_q <= meta_q;
        end
      end
      assign q_o[g] = sync_q;
    end
  endgenerate
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic act_i,
  output logic rst_o,
  output logic entry_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || act_i) begin
      cnt_q <= CW'(HOLD);
      rst_q <= 1'b1;
    end else begin
      rst_q <= (cnt_q != '0);
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rst_o   = rst_q;
  assign entry_o = act_i & ~rst_q;

  AST_RST_FOLLOWS_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
    act_i |=> rst_q); // R10
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_q) |-> (!$past(act_i) && !$past(act_i, 2))); // R10
endmodule

// File: rtl/rcc_pulse.sv
module rcc_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          pulse_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= CW'(LEN);
      pulse_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
      pulse_q <= (cnt_q != CW'(1));
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rcc_cause.sv
module rcc_cause
  import rcc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic cap_i,
  input  src_t src_i,
  output src_t flags_o
);
  src_t flags_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      flags_q <= src_t'(1) << B_POR;
    else if (cap_i) flags_q <= pick_cause(src_i);
  end

  assign flags_o = flags_q;

  AST_FLAG_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(flags_q) == 1); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !cap_i |=> $stable(flags_q)); // R9
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       mon_en_i,
  input  logic       supply_low_i,
  input  logic       pin_rst_n_i,
  input  logic       wdt_expire_i,
  input  logic       clk_lost_i,
  input  logic       cmp_out_i,
  input  logic       cnv_start_n_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sys_rst_o,
  output logic       pin_drive_o
);
  localparam int NA    = 6;
  localparam int A_SUP = 0;
  localparam int A_PIN = 1;
  localparam int A_WDT = 2;
  localparam int A_CLK = 3;
  localparam int A_CMP = 4;
  localparam int A_CNV = 5;
  localparam logic [NA-1:0] A_IDLE = 6'b110010;

  logic [NA-1:0] a_raw, a_s;
  src_t          src, flags;
  en_t           en_q;
  logic          rst_q, entry, any_act, wr_ok, force_por, force_sw;

  assign a_raw = {cnv_start_n_i, cmp_out_i, clk_lost_i, wdt_expire_i, pin_rst_n_i, supply_low_i};

  rcc_sync #(.W(NA), .IDLE(A_IDLE)) u_sync (
    .clk_i (clk_i), .rst_i (por_i), .d_i (a_raw), .q_o (a_s)
  );

  assign wr_ok     = wr_en_i & ~rst_q;
  assign force_por = wr_ok & wdata_i[B_PIN];
  assign force_sw  = wr_ok & wdata_i[B_SW];

  always_comb begin
    src         = '0;
    src[B_POR]  = por_i | force_por | (mon_en_i & en_q.mon & a_s[A_SUP]);
    src[B_PIN]  = ~a_s[A_PIN];
    src[B_MCD]  = en_q.mcd & a_s[A_CLK];
    src[B_WDT]  = a_s[A_WDT];
    src[B_SW]   = force_sw;
    src[B_CMP]  = en_q.cmp & ~a_s[A_CMP];
    src[B_CNV]  = en_q.cnv & ~a_s[A_CNV];
  end

  assign any_act = |src;

  rcc_stretch #(.HOLD(STRETCH)) u_stretch (
    .clk_i (clk_i), .rst_i (por_i), .act_i (any_act), .rst_o (rst_q), .entry_o (entry)
  );

  rcc_cause u_cause (
    .clk_i (clk_i), .rst_i (por_i), .cap_i (entry), .src_i (src), .flags_o (flags)
  );

  rcc_pulse #(.LEN(STRETCH)) u_pin (
    .clk_i (clk_i), .rst_i (por_i), .start_i (force_por), .pulse_o (pin_drive_o)
  );

  always_ff @(posedge clk_i) begin
    if (por_i || (entry && src[B_POR])) begin
      en_q <= '0;
    end else if (wr_ok) begin
      en_q.cnv <= wdata_i[B_CNV];
      en_q.cmp <= wdata_i[B_CMP];
      en_q.mcd <= wdata_i[B_MCD];
      en_q.mon <= wdata_i[B_POR];
    end
  end

  assign rdata_o   = {1'b0, flags};
  assign sys_rst_o = rst_q;

  AST_PIN_FROM_WRITE: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(pin_drive_o) |-> $past(wr_en_i && wdata_i[B_PIN] && !sys_rst_o)); // R6
  AST_EN_FROZEN_IN_RST: assert property (@(posedge clk_i) disable iff (por_i)
    sys_rst_o |=> $stable(en_q)); // R12
endmodule

// File: tb/rst_cause_ctrl_test.sv
`timescale 1ns/1ps
module rst_cause_ctrl_test;
  localparam int S  = 16;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic por = 1'b1, mon_en = 1'b0, sup_low = 1'b0, pin_n = 1'b1, wdt = 1'b0;
  logic lost = 1'b0, cmp = 1'b1, cnv_n = 1'b1, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sys_rst, pin_drv;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rst_cause_ctrl #(.STRETCH(S)) uut (
    .clk_i(clk), .por_i(por), .mon_en_i(mon_en), .supply_low_i(sup_low),
    .pin_rst_n_i(pin_n), .wdt_expire_i(wdt), .clk_lost_i(lost), .cmp_out_i(cmp),
    .cnv_start_n_i(cnv_n), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .sys_rst_o(sys_rst), .pin_drive_o(pin_drv)
  );

  // {enable write[24:17], action[16:9], reset expected[8], cause expected[7:0]}
  // action: 0 pin low, 1 supply low, 2 clock lost, 3 watchdog, 4 sw write,
  //         5 comparator low, 6 convert-start low, 7 mon_en_i level
  localparam logic [24:0] VEC [NV] = '{
    {8'h00, 8'h10, 1'b1, 8'h10},  // R5 software warm reset
    {8'h00, 8'h01, 1'b1, 8'h01},  // R7 pin
    {8'h00, 8'h08, 1'b1, 8'h08},  // R7 watchdog
    {8'h00, 8'h04, 1'b0, 8'h08},  // R3 lost clock disarmed, R9 cause held
    {8'h04, 8'h04, 1'b1, 8'h04},  // R3 lost clock armed
    {8'h20, 8'h20, 1'b1, 8'h20},  // R3 comparator armed
    {8'h40, 8'h40, 1'b1, 8'h40},  // R3 convert-start armed
    {8'h00, 8'h20, 1'b0, 8'h40},  // R3 comparator disarmed, R9
    {8'h02, 8'h82, 1'b1, 8'h02},  // R4 monitor selected and enabled
    {8'h00, 8'h82, 1'b0, 8'h02},  // R4 monitor not selected
    {8'h02, 8'h02, 1'b0, 8'h02},  // R4 monitor strap low
    {8'h24, 8'h2C, 1'b1, 8'h04},  // R8 lost clock over watchdog and comparator
    {8'h00, 8'h09, 1'b1, 8'h01},  // R8 pin over watchdog
    {8'h60, 8'h60, 1'b1, 8'h20},  // R8 comparator over convert-start
    {8'h02, 8'h8B, 1'b1, 8'h02}   // R8 power-on class over pin
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
  endtask

  // counts high samples of sys_rst and pin_drive until reset ends
  task automatic drain(output int nr, output int np);
    nr = 0; np = 0;
    while (sys_rst && nr < 400) begin
      nr++;
      if (pin_drv) np++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_pulse(output logic saw);
    int nr, np;
    saw = 1'b0;
    @(negedge clk); cmp = 1'b0;
    repeat (4) begin @(negedge clk); saw |= sys_rst; end
    cmp = 1'b1;
    drain(nr, np);
    if (nr != 0) saw = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input logic [24:0] v, output logic saw, output logic pd);
    logic [7:0] en, act;
    int nr, np;
    en = v[24:17]; act = v[16:9];
    wr(en);
    mon_en = act[7];
    saw = 1'b0; pd = 1'b0;
    if (act[4]) begin
      wr(en | 8'h10);
    end else begin
      @(negedge clk);
      pin_n = ~act[0]; sup_low = act[1]; lost = act[2]; wdt = act[3];
      cmp = ~act[5]; cnv_n = ~act[6];
      repeat (4) begin @(negedge clk); saw |= sys_rst; end
      pin_n = 1'b1; sup_low = 1'b0; lost = 1'b0; wdt = 1'b0; cmp = 1'b1; cnv_n = 1'b1;
    end
    drain(nr, np);
    if (nr != 0) saw = 1'b1;
    if (np != 0) pd = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic saw, pd;
    int nr, np;
    repeat (5) @(negedge clk);
    chk("R2 reset held", sys_rst, 1);
    por = 1'b0;
    drain(nr, np);
    repeat (2) @(negedge clk);
    chk("R2 cause after power-on", rdata, 8'h02);
    chk("R2 reset released", sys_rst, 0);
    wdata = 8'h00;
    mon_en = 1'b0;
    @(negedge clk); cmp = 1'b0;           // R2 comparator disarmed after power-on
    repeat (4) @(negedge clk);
    chk("R2 no reset from disarmed source", sys_rst, 0);
    cmp = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], saw, pd);
      chk($sformatf("vector %0d reset seen (R3/R4/R5/R7/R8/R9)", i), saw, VEC[i][8]);
      chk($sformatf("vector %0d cause (R1/R3/R4/R5/R7/R8/R9)", i), rdata, VEC[i][7:0]);
      chk($sformatf("vector %0d pin drive idle (R5)", i), pd, 0);
    end

    // R10: one-cycle software request gives STRETCH+1 cycles, no pin drive (R5)
    wr(8'h10);
    drain(nr, np);
    chk("R10 software reset length", nr, S + 1);
    chk("R5 software reset leaves pin alone", np, 0);
    repeat (2) @(negedge clk);

    // R11: enable survives warm reset
    wr(8'h20);
    wr(8'h30);
    drain(nr, np);
    repeat (2) @(negedge clk);
    cmp_pulse(saw);
    chk("R11 comparator still armed after warm reset", saw, 1);
    chk("R11 cause comparator", rdata, 8'h20);

    // R6: power-on-style request, R11 clears enables
    wr(8'h20);
    wr(8'h21);
    drain(nr, np);
    chk("R6 pin drive length", np, S);
    chk("R6 reset length", nr, S + 1);
    repeat (2) @(negedge clk);
    chk("R6 cause power-on class", rdata, 8'h02);
    cmp_pulse(saw);
    chk("R11 comparator disarmed by power-on class", saw, 0);

    // R12: write during reset dropped
    wr(8'h10);
    chk("R12 in reset before write", sys_rst, 1);
    wr(8'h20);
    drain(nr, np);
    repeat (2) @(negedge clk);
    chk("R12 cause unchanged", rdata, 8'h10);
    cmp_pulse(saw);
    chk("R12 arming write in reset dropped", saw, 0);

    // R5: write of zeros starts nothing
    wr(8'h00);
    repeat (2) @(negedge clk);
    chk("R5 zero write no reset", sys_rst, 0);
    chk("R1 bit 7 reads zero", rdata[7], 0);

    // R10: long pin reset, length counted from release
    @(negedge clk); pin_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10 reset held while pin low", sys_rst, 1);
    pin_n = 1'b1;
    @(negedge clk);
    drain(nr, np);
    chk("R10 pin release stretch", nr, S + 2);
    chk("R7 pin cause", rdata, 8'h01);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule